// File: doc/BRIEF.md
# Selective Load-Use Interlock Unit

This block sits beside the decode stage of a five-stage in-order integer pipeline. Each cycle it looks at the instruction in the execute stage and at the instruction waiting in decode. The unit raises a one-cycle interlock only when the execute-stage instruction is a load and the decode-stage instruction must have the loaded value before memory returns it. During that cycle the fetch and decode stages keep their contents and the execute stage takes a bubble. In the cycle after that, the operand is taken from the memory stage by the forwarding network, which lies outside this block.

Many load/consumer pairs can be resolved by forwarding alone, and the unit leaves those running at full rate. Two examples are a store whose data register is the loaded register, and a move-from-coprocessor that reads no general register. The decode stage gives an instruction class code and its two source indices. From the class, the unit knows which of those indices the instruction really reads, and it compares only those indices with the load's destination. After a stall, the execute slot holds the bubble, so the unit never raises a second stall in the next cycle.

Top module: `load_use_interlock`

## Requirements
- R1: When a hazard is found, `fetch_hold_o`, `decode_hold_o` and `exec_flush_o` all go to 1 in the same cycle as the inputs that cause it. They carry the same value in every cycle.
- R2: Some classes read their first source index (`dec_src_a_i`): ALU register-register (1), ALU immediate (2), load (3), store (4), multiply (5), branch-if-equal (6), jump-register (7) and jump-and-link-register (8). For these classes a stall is raised when that index equals a non-zero `exe_dst_i` and `exe_is_load_i` is 1.
- R3: Some classes read their second source index (`dec_src_b_i`): ALU register-register (1), multiply (5), branch-if-equal (6) and move-to-coprocessor (9). For these classes a stall is raised when that index equals a non-zero load destination.
- R4: A source index that the class does not read has no effect. Examples are the second index of ALU immediate, load, jump-register and jump-and-link-register, and the first index of move-to-coprocessor.
- R5: A store (4) whose second index (the data register) matches the load destination does not stall, provided its first index (the base) does not match.
- R6: These classes never stall: move-from-coprocessor (10), jump-and-link (11), move-from-multiply-result (12), no-operation (0), and the unused codes 13 to 15.
- R7: A load whose destination index is 0 never stalls.
- R8: When `exe_is_load_i` is 0, no stall occurs, whatever the other inputs are.
- R9: A stall lasts exactly one cycle. If the inputs stay the same across the clock edge, the next cycle has no stall. The cycle after that stalls again.
- R10: All three outputs are 0 while `rst_n` is low, even if hazard inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exe_is_load_i | input | 1 | Execute-stage instruction is a load |
| exe_dst_i | input | 5 | Destination register index of the execute-stage instruction |
| dec_class_i | input | 4 | Class code of the decode-stage instruction |
| dec_src_a_i | input | 5 | First source register index in decode (base / rs) |
| dec_src_b_i | input | 5 | Second source register index in decode (data / rt) |
| fetch_hold_o | output | 1 | Fetch stage keeps its contents |
| decode_hold_o | output | 1 | Decode stage keeps its contents |
| exec_flush_o | output | 1 | Execute stage is replaced by a bubble |

## Verification
Every class code is applied three ways against a non-zero load destination: with a match on the first index only, with a match on the second index only, and with no match. Together these patterns show which fields each class compares, and that no class compares a field it does not read. Stores are tried with a data-only match and with a base match, which separates forwarding-resolved cases from true hazards. A hazard held steady across two edges separates a single-cycle stall from a stuck one. A zero destination and a cleared load flag show that the match logic is gated correctly.

// File: rtl/lu_pkg.sv
package lu_pkg;

  localparam int unsigned REG_W = 5;
  localparam int unsigned CLS_W = 4;
  localparam int unsigned NUM_SRC = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_NOP    = 4'd0,
    CLS_ALU_RR = 4'd1,
    CLS_ALU_RI = 4'd2,
    CLS_LOAD   = 4'd3,
    CLS_STORE  = 4'd4,
    CLS_MULT   = 4'd5,
    CLS_BEQ    = 4'd6,
    CLS_JR     = 4'd7,
    CLS_JALR   = 4'd8,
    CLS_MTCOP  = 4'd9,
    CLS_MFCOP  = 4'd10,
    CLS_JAL    = 4'd11,
    CLS_MFMUL  = 4'd12
  } cls_e;

  typedef struct packed {
    logic use_a;
    logic use_b;
  } src_use_t;

endpackage

// File: rtl/lu_operand_decode.sv
module lu_operand_decode
  import lu_pkg::*;
#(
  parameter int unsigned CW = CLS_W
) (
  input  logic [CW-1:0] class_i,
  output src_use_t      use_o
);

  always_comb begin
    use_o = '0;
    case (class_i)
      CLS_ALU_RR: use_o = '{use_a: 1'b1, use_b: 1'b1};
      CLS_ALU_RI: use_o = '{use_a: 1'b1, use_b: 1'b0};
      CLS_LOAD:   use_o = '{use_a: 1'b1, use_b: 1'b0};
      // store data register is served by memory-data forwarding
      CLS_STORE:  use_o = '{use_a: 1'b1, use_b: 1'b0};
      CLS_MULT:   use_o = '{use_a: 1'b1, use_b: 1'b1};
      CLS_BEQ:    use_o = '{use_a: 1'b1, use_b: 1'b1};
      CLS_JR:     use_o = '{use_a: 1'b1, use_b: 1'b0};
      CLS_JALR:   use_o = '{use_a: 1'b1, use_b: 1'b0};
      CLS_MTCOP:  use_o = '{use_a: 1'b0, use_b: 1'b1};
      default:    use_o = '0;
    endcase
  end

endmodule

// File: rtl/lu_field_match.sv
module lu_field_match #(
  parameter int unsigned RW = 5,
  parameter int unsigned NS = 2
) (
  input  logic [NS-1:0][RW-1:0] src_idx_i,
  input  logic [NS-1:0]         src_used_i,
  input  logic                  load_i,
  input  logic [RW-1:0]         dst_i,
  output logic [NS-1:0]         hit_o,
  output logic                  any_hit_o
);

  logic dst_live;

  always_comb begin
    dst_live = load_i && (dst_i != '0);
  end

  for (genvar g = 0; g < NS; g++) begin : g_src
    always_comb begin
      hit_o[g] = dst_live && src_used_i[g] && (src_idx_i[g] == dst_i);
    end
  end

  always_comb begin
    any_hit_o = |hit_o;
  end

endmodule

// File: rtl/lu_stall_seq.sv
module lu_stall_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic hazard_i,
  output logic stall_o
);

  logic armed_q, armed_d;
  logic guard_q, guard_d;

  // next state
  always_comb begin
    stall_o = hazard_i && armed_q && !guard_q;
    armed_d = 1'b1;
    guard_d = stall_o;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      guard_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      guard_q <= guard_d;
    end
  end

endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
  import lu_pkg::*;
#(
  parameter int unsigned RW = REG_W,
  parameter int unsigned CW = CLS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exe_is_load_i,
  input  logic [RW-1:0] exe_dst_i,
  input  logic [CW-1:0] dec_class_i,
  input  logic [RW-1:0] dec_src_a_i,
  input  logic [RW-1:0] dec_src_b_i,
  output logic          fetch_hold_o,
  output logic          decode_hold_o,
  output logic          exec_flush_o
);

  localparam int unsigned NS = NUM_SRC;

  src_use_t             use_w;
  logic [NS-1:0][RW-1:0] src_idx;
  logic [NS-1:0]         src_used;
  logic [NS-1:0]         hit;
  logic                  hazard;
  logic                  stall;

  always_comb begin
    src_idx[0]  = dec_src_a_i;
    src_idx[1]  = dec_src_b_i;
    src_used[0] = use_w.use_a;
    src_used[1] = use_w.use_b;
  end

  lu_operand_decode #(.CW(CW)) u_decode (
    .class_i (dec_class_i),
    .use_o   (use_w)
  );

  lu_field_match #(.RW(RW), .NS(NS)) u_match (
    .src_idx_i  (src_idx),
    .src_used_i (src_used),
    .load_i     (exe_is_load_i),
    .dst_i      (exe_dst_i),
    .hit_o      (hit),
    .any_hit_o  (hazard)
  );

  lu_stall_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hazard_i (hazard),
    .stall_o  (stall)
  );

  always_comb begin
    fetch_hold_o  = stall;
    decode_hold_o = stall;
    exec_flush_o  = stall;
  end

endmodule

// File: rtl/load_use_interlock_chk.sv
module load_use_interlock_chk
  import lu_pkg::*;
#(
  parameter int unsigned RW = REG_W,
  parameter int unsigned CW = CLS_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exe_is_load_i,
  input logic [RW-1:0] exe_dst_i,
  input logic [CW-1:0] dec_class_i,
  input logic [RW-1:0] dec_src_a_i,
  input logic [RW-1:0] dec_src_b_i,
  input logic          fetch_hold_o,
  input logic          decode_hold_o,
  input logic          exec_flush_o
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic silent_cls;
  always_comb begin
    silent_cls = (dec_class_i == CLS_MFCOP) || (dec_class_i == CLS_JAL) ||
                 (dec_class_i == CLS_MFMUL) || (dec_class_i == CLS_NOP) ||
                 (dec_class_i > CLS_MFMUL);
  end

  assert_holds_agree_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_hold_o == exec_flush_o) && (decode_hold_o == exec_flush_o));

  assert_src_a_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && exe_is_load_i && exe_dst_i != '0 && dec_class_i == CLS_ALU_RI &&
     dec_src_a_i == exe_dst_i && !$past(exec_flush_o)) |-> exec_flush_o);

  assert_src_b_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && exe_is_load_i && exe_dst_i != '0 && dec_class_i == CLS_MTCOP &&
     dec_src_b_i == exe_dst_i && !$past(exec_flush_o)) |-> exec_flush_o);

  assert_store_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_class_i == CLS_STORE && dec_src_a_i != exe_dst_i) |-> !exec_flush_o);

  assert_silent_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    silent_cls |-> !exec_flush_o);

  assert_zero_dst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_dst_i == '0) |-> !exec_flush_o);

  assert_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !exe_is_load_i |-> !exec_flush_o);

  assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_flush_o |=> !exec_flush_o);

endmodule

bind load_use_interlock load_use_interlock_chk #(.RW(RW), .CW(CW)) u_chk (.*);

// File: tb/load_use_interlock_tb.sv
`timescale 1ns/1ps
module load_use_interlock_tb;

  logic       clk;
  logic       rst_n;
  logic       ld;
  logic [4:0] dst;
  logic [3:0] cls;
  logic [4:0] sa;
  logic [4:0] sb;
  logic       h_f, h_d, fl;

  int n_chk = 0;
  int n_bad = 0;

  load_use_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .exe_is_load_i(ld), .exe_dst_i(dst),
    .dec_class_i(cls), .dec_src_a_i(sa), .dec_src_b_i(sb),
    .fetch_hold_o(h_f), .decode_hold_o(h_d), .exec_flush_o(fl));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // expected use of each source field, from the requirements table
  function automatic bit reads_a(input int c);
    return (c >= 1 && c <= 8);
  endfunction
  function automatic bit reads_b(input int c);
    return (c == 1 || c == 5 || c == 6 || c == 9);
  endfunction
  function automatic bit model(input bit l, input int d, input int c,
                               input int a, input int b);
    if (!l || d == 0) return 1'b0;
    return (reads_a(c) && a == d) || (reads_b(c) && b == d);
  endfunction

  task automatic expect3(input string req, input bit exp);
    n_chk++;
    if (h_f !== exp || h_d !== exp || fl !== exp) begin
      n_bad++;
      $display("FAIL %s: got fetch=%b decode=%b flush=%b expected %b (cls=%0d a=%0d b=%0d dst=%0d ld=%b)",
               req, h_f, h_d, fl, exp, cls, sa, sb, dst, ld);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ld = 1'b0; dst = '0; cls = '0; sa = '0; sb = '0;
  endtask

  task automatic apply(input string req, input bit l, input int d,
                       input int c, input int a, input int b);
    idle();
    @(negedge clk);
    ld = l; dst = 5'(d); cls = 4'(c); sa = 5'(a); sb = 5'(b);
    #1;
    expect3(req, model(l, d, c, a, b));
  endtask

  // R10: reset keeps outputs low
  task automatic t_reset();
    rst_n = 1'b0;
    ld = 1'b1; dst = 5'd3; cls = 4'd1; sa = 5'd3; sb = 5'd3;
    #1;  expect3("R10", 1'b0);
    repeat (3) @(posedge clk);
    #1;  expect3("R10", 1'b0);
    @(negedge clk); rst_n = 1'b1;
    idle(); idle();
  endtask

  // R2 R3 R1: every class, match on a only, b only, neither
  task automatic t_class_sweep();
    for (int c = 0; c < 16; c++) begin
      apply("R2", 1'b1, 7, c, 7, 12);
      apply("R3", 1'b1, 7, c, 12, 7);
      apply("R1", 1'b1, 7, c, 12, 13);
    end
  endtask

  // R4: unread fields ignored
  task automatic t_unread();
    apply("R4", 1'b1, 9, 2, 4, 9);   // alu immediate, b matches
    apply("R4", 1'b1, 9, 3, 4, 9);   // load, b matches
    apply("R4", 1'b1, 31, 7, 1, 31); // jump-register
    apply("R4", 1'b1, 31, 8, 1, 31); // jump-and-link-register
    apply("R4", 1'b1, 9, 9, 9, 4);   // move-to-coprocessor, a matches
  endtask

  // R5: store data vs base
  task automatic t_store();
    apply("R5", 1'b1, 5, 4, 6, 5);
    apply("R5", 1'b1, 5, 4, 5, 6);
    apply("R5", 1'b1, 5, 4, 5, 5);
  endtask

  // R6: silent classes even when both fields match
  task automatic t_silent();
    for (int c = 10; c < 16; c++) apply("R6", 1'b1, 8, c, 8, 8);
    apply("R6", 1'b1, 8, 0, 8, 8);
  endtask

  // R7: zero destination
  task automatic t_zero();
    apply("R7", 1'b1, 0, 1, 0, 0);
    apply("R7", 1'b1, 0, 6, 0, 0);
  endtask

  // R8: no load
  task automatic t_noload();
    apply("R8", 1'b0, 4, 1, 4, 4);
    apply("R8", 1'b0, 4, 9, 4, 4);
  endtask

  // R9: single-cycle stall with inputs held
  task automatic t_repeat();
    apply("R9", 1'b1, 11, 5, 11, 2);
    @(negedge clk); #1; expect3("R9", 1'b0);
    @(negedge clk); #1; expect3("R9", 1'b1);
  endtask

  initial begin
    ld = 1'b0; dst = '0; cls = '0; sa = '0; sb = '0;
    t_reset();
    t_class_sweep();
    t_unread();
    t_store();
    t_silent();
    t_zero();
    t_noload();
    t_repeat();
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule